// File: doc/BRIEF.md
# Semaphore-Paced Descriptor Chain Sequencer

This block is a single DMA channel front end. It walks a linked list of three-word command descriptors held in memory. Software first loads the address of the first descriptor. It then adds a count to an 8-bit hardware semaphore and clears the channel's clock-gate bit. From then on the engine repeats the same loop. It fetches the descriptor at the current next-command address over an in-order read port. It hands the buffer address and transfer count to a data mover through a valid/ready handshake, and waits for the mover's done pulse. At that point it may decrement the semaphore, flag completion, and follow the descriptor's link. The loop continues while the semaphore is non-zero.

Because the semaphore counts commands still to be done, software can lengthen a running chain by adding to it, with no restart. A command that ends the list while the semaphore still expects more work is treated as a fault: the channel parks until software acknowledges it. Control and interrupt registers each have a plain write address, a bit-set address and a bit-clear address.

Top module: `desc_chain_seq`

## Requirements
- R1: After reset the clock-gate bit reads 1, the semaphore, next-command address, status and enable bits read 0, `irq` is 0, and neither `mem_req_valid` nor `cmd_valid` is asserted.
- R2: Register word addresses: control at 0/1/2, interrupt at 4/5/6, next-command at 8, semaphore at 12. For control and interrupt, the first address of each triple replaces the register, the second ORs the written ones in, and the third clears the written ones, leaving other bits unchanged. Reads are returned on `reg_rdata` one cycle after `reg_addr` is presented.
- R3: Writing the semaphore adds `reg_wdata[7:0]` to the current count, whether or not the channel is running, saturating at 255. The count is readable at any time.
- R4: With the clock-gate bit (control bit 0) clear, the semaphore non-zero and no error pending, the engine reads three words at A, A+4 and A+8. Here A is the next-command address. The words are, in order, the link address, the control word, and the buffer address. In the control word, bits 15:0 are the transfer count, bit 16 is chain, bit 17 is decrement-semaphore, and bit 18 is interrupt-on-complete.
- R5: The engine then presents the buffer address and count with `cmd_valid` held stable until `cmd_ready`. The command finishes on the next `xfer_done` pulse.
- R6: On finishing, the semaphore drops by one only if the decrement flag was set, never below 0. Otherwise it is unchanged and execution continues.
- R7: On finishing a command with chain set, the next-command register is loaded from its link word. The engine keeps fetching while the semaphore is non-zero and stops when it reaches 0.
- R8: A command that finishes with chain clear while the semaphore is still non-zero sets error status (interrupt bit 1). The engine stays idle until that bit is cleared. Chain clear with the semaphore at 0 is a normal end.
- R9: A command with interrupt-on-complete set sets done status (interrupt bit 0) when it finishes. The enables sit 8 bits higher (bits 8 and 9). `irq` is the registered OR of status AND enable.
- R10: Setting the clock-gate bit stops the engine on the following cycle, abandoning any fetch or command. The semaphore is kept.
- R11: Writing 1 to control bit 1 resets the channel: the engine goes idle and the semaphore becomes 0. The bit always reads 0.
- R12: `mem_req_valid` with a stable address is held until `mem_req_ready`. Only one read is outstanding at a time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Registered read data |
| mem_req_valid | output | 1 | Descriptor read request |
| mem_req_ready | input | 1 | Read request accepted |
| mem_req_addr | output | 32 | Descriptor word byte address |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | 32 | Read data |
| cmd_valid | output | 1 | Transfer command valid |
| cmd_ready | input | 1 | Data mover accepts command |
| cmd_addr | output | 32 | Buffer address of the command |
| cmd_count | output | 16 | Transfer count of the command |
| xfer_done | input | 1 | Data mover finished the command |
| irq | output | 1 | Interrupt request |

## Verification
The bench goes after the points where the semaphore and the chain link disagree:
- A chain that loops forever but is cut off when the count hits 0. A design that ignores the count would run away.
- A command without the decrement flag. A design that always decrements would stop one command early.
- A list end reached with count left. A design that skips the fault would either restart the final descriptor or silently drop work.

It also adds to the count during a running command, gates the channel while a command waits for acceptance, and sweeps counts 1 to 6 around a four-entry ring, with and without read-port stalls. A wrong abort or a wrong link load shows up as extra commands or a wrong final next-command address.

// File: rtl/dcs_pkg.sv
package dcs_pkg;
  typedef enum logic [2:0] {ST_IDLE, ST_REQ, ST_RSP, ST_CMD, ST_WAIT} eng_st_e;

  // register groups (reg_addr[3:2]) and alias kinds (reg_addr[1:0])
  localparam logic [1:0] RG_CTL = 2'd0;
  localparam logic [1:0] RG_INT = 2'd1;
  localparam logic [1:0] RG_NXT = 2'd2;
  localparam logic [1:0] RG_SEM = 2'd3;
  localparam logic [1:0] AL_SET = 2'd1;
  localparam logic [1:0] AL_CLR = 2'd2;

  localparam int CTL_GATE   = 0;
  localparam int CTL_RST    = 1;
  localparam int INT_DONE   = 0;
  localparam int INT_ERR    = 1;
  localparam int INT_EN_OFS = 8;

  localparam int BIT_CHAIN = 16;
  localparam int BIT_DEC   = 17;
  localparam int BIT_IRQ   = 18;

  function automatic logic [31:0] alias_wr(input logic [31:0] old,
                                           input logic [31:0] w,
                                           input logic [1:0]  al);
    case (al)
      AL_SET:  return old | w;
      AL_CLR:  return old & ~w;
      default: return w;
    endcase
  endfunction
endpackage

// File: rtl/dcs_engine.sv
module dcs_engine
  import dcs_pkg::*;
#(
  parameter int AW = 32,
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          halt,
  input  logic          go,
  input  logic [AW-1:0] start_addr,
  output logic          mem_req_valid,
  input  logic          mem_req_ready,
  output logic [AW-1:0] mem_req_addr,
  input  logic          mem_rsp_valid,
  input  logic [31:0]   mem_rsp_data,
  output logic          cmd_valid,
  input  logic          cmd_ready,
  output logic [AW-1:0] cmd_addr,
  output logic [CW-1:0] cmd_count,
  input  logic          xfer_done,
  output logic          fin,
  output logic          fin_chain,
  output logic          fin_dec,
  output logic          fin_irq,
  output logic [AW-1:0] fin_next
);
  localparam int NWORDS = 3;
  localparam int IW     = $clog2(NWORDS);
  localparam logic [IW-1:0] LAST_W = IW'(NWORDS - 1);

  eng_st_e       st;
  logic [IW-1:0] widx;
  logic [AW-1:0] base;
  logic [31:0]   dw [NWORDS];

  always_ff @(posedge clk) begin
    if (rst) begin
      st   <= ST_IDLE;
      widx <= '0;
      base <= '0;
    end else if (halt && st != ST_IDLE) begin
      st <= ST_IDLE;
    end else begin
      case (st)
        ST_IDLE: if (go && !halt) begin
          st   <= ST_REQ;
          widx <= '0;
          base <= start_addr;
        end
        ST_REQ:  if (mem_req_ready) st <= ST_RSP;
        ST_RSP:  if (mem_rsp_valid) begin
          if (widx == LAST_W) st <= ST_CMD;
          else begin
            widx <= widx + 1'b1;
            st   <= ST_REQ;
          end
        end
        ST_CMD:  if (cmd_ready) st <= ST_WAIT;
        ST_WAIT: if (xfer_done) st <= ST_IDLE;
        default: st <= ST_IDLE;
      endcase
    end
  end

  // descriptor word store, no reset
  always_ff @(posedge clk) begin
    if (st == ST_RSP && mem_rsp_valid && !halt) dw[widx] <= mem_rsp_data;
  end

  assign mem_req_valid = (st == ST_REQ);
  assign mem_req_addr  = base + {{(AW-IW-2){1'b0}}, widx, 2'b00};
  assign cmd_valid     = (st == ST_CMD);
  assign cmd_addr      = dw[2][AW-1:0];
  assign cmd_count     = dw[1][CW-1:0];
  assign fin           = (st == ST_WAIT) && xfer_done && !halt;
  assign fin_chain     = dw[1][BIT_CHAIN];
  assign fin_dec       = dw[1][BIT_DEC];
  assign fin_irq       = dw[1][BIT_IRQ];
  assign fin_next      = dw[0][AW-1:0];
endmodule

// File: rtl/dcs_regs.sv
module dcs_regs
  import dcs_pkg::*;
#(
  parameter int AW  = 32,
  parameter int SW  = 8,
  parameter int RAW = 4
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           reg_we,
  input  logic [RAW-1:0] reg_addr,
  input  logic [31:0]    reg_wdata,
  output logic [31:0]    reg_rdata,
  input  logic           fin,
  input  logic           fin_chain,
  input  logic           fin_dec,
  input  logic           fin_irq,
  input  logic [AW-1:0]  fin_next,
  output logic           gate,
  output logic           chan_rst,
  output logic           err_st,
  output logic [SW-1:0]  sema,
  output logic [AW-1:0]  nxt,
  output logic           irq
);
  localparam logic [31:0] INT_MASK = 32'd3 | (32'd3 << INT_EN_OFS);
  localparam logic [SW-1:0] SEM_MAX = '1;

  logic [1:0]    grp, al;
  logic [31:0]   ctl_new, int_q, int_new, int_hw;
  logic [SW-1:0] sema_dec;
  logic [SW:0]   sema_sum;
  logic          err_set;

  assign grp = reg_addr[3:2];
  assign al  = reg_addr[1:0];

  assign ctl_new  = alias_wr(32'(gate), reg_wdata, al);
  assign int_new  = (reg_we && grp == RG_INT) ? alias_wr(int_q, reg_wdata, al) : int_q;
  assign sema_dec = (fin && fin_dec && sema != '0) ? sema - 1'b1 : sema;
  assign sema_sum = {1'b0, sema_dec} +
                    ((reg_we && grp == RG_SEM) ? {1'b0, reg_wdata[SW-1:0]} : '0);
  assign err_set  = fin && !fin_chain && sema_dec != '0;
  assign int_hw   = (32'(fin && fin_irq) << INT_DONE) | (32'(err_set) << INT_ERR);
  assign err_st   = int_q[INT_ERR];

  always_ff @(posedge clk) begin
    if (rst) begin
      gate      <= 1'b1;
      chan_rst  <= 1'b0;
      int_q     <= '0;
      nxt       <= '0;
      sema      <= '0;
      irq       <= 1'b0;
      reg_rdata <= '0;
    end else begin
      if (reg_we && grp == RG_CTL) gate <= ctl_new[CTL_GATE];
      chan_rst <= reg_we && grp == RG_CTL && ctl_new[CTL_RST];
      int_q    <= (int_new | int_hw) & INT_MASK;
      if (fin && fin_chain)              nxt <= fin_next;
      else if (reg_we && grp == RG_NXT)  nxt <= reg_wdata[AW-1:0];
      if (chan_rst)          sema <= '0;
      else if (sema_sum[SW]) sema <= SEM_MAX;
      else                   sema <= sema_sum[SW-1:0];
      irq <= |(int_q[1:0] & int_q[INT_EN_OFS+1:INT_EN_OFS]);
      case (grp)
        RG_CTL:  reg_rdata <= 32'(gate);
        RG_INT:  reg_rdata <= int_q;
        RG_NXT:  reg_rdata <= 32'(nxt);
        default: reg_rdata <= 32'(sema);
      endcase
    end
  end
endmodule

// File: rtl/desc_chain_seq.sv
module desc_chain_seq
  import dcs_pkg::*;
#(
  parameter int AW  = 32,
  parameter int CW  = 16,
  parameter int SW  = 8,
  parameter int RAW = 4
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           reg_we,
  input  logic [RAW-1:0] reg_addr,
  input  logic [31:0]    reg_wdata,
  output logic [31:0]    reg_rdata,
  output logic           mem_req_valid,
  input  logic           mem_req_ready,
  output logic [AW-1:0]  mem_req_addr,
  input  logic           mem_rsp_valid,
  input  logic [31:0]    mem_rsp_data,
  output logic           cmd_valid,
  input  logic           cmd_ready,
  output logic [AW-1:0]  cmd_addr,
  output logic [CW-1:0]  cmd_count,
  input  logic           xfer_done,
  output logic           irq
);
  logic          gate, chan_rst, err_st, fin, fin_chain, fin_dec, fin_irq;
  logic [SW-1:0] sema;
  logic [AW-1:0] nxt, fin_next;

  dcs_regs #(.AW(AW), .SW(SW), .RAW(RAW)) u_regs (
    .clk, .rst, .reg_we, .reg_addr, .reg_wdata, .reg_rdata,
    .fin, .fin_chain, .fin_dec, .fin_irq, .fin_next,
    .gate, .chan_rst, .err_st, .sema, .nxt, .irq
  );

  dcs_engine #(.AW(AW), .CW(CW)) u_eng (
    .clk, .rst,
    .halt       (gate | chan_rst | err_st),
    .go         (sema != '0),
    .start_addr (nxt),
    .mem_req_valid, .mem_req_ready, .mem_req_addr, .mem_rsp_valid, .mem_rsp_data,
    .cmd_valid, .cmd_ready, .cmd_addr, .cmd_count, .xfer_done,
    .fin, .fin_chain, .fin_dec, .fin_irq, .fin_next
  );
endmodule

// File: rtl/dcs_chk.sv
module dcs_chk #(
  parameter int AW  = 32,
  parameter int SW  = 8,
  parameter int RAW = 4
) (
  input logic           clk,
  input logic           rst,
  input logic           gate,
  input logic           chan_rst,
  input logic           err_st,
  input logic [SW-1:0]  sema,
  input logic           reg_we,
  input logic [RAW-1:0] reg_addr,
  input logic           mem_req_valid,
  input logic           mem_req_ready,
  input logic [AW-1:0]  mem_req_addr,
  input logic           cmd_valid,
  input logic           cmd_ready,
  input logic [AW-1:0]  cmd_addr
);
  logic sem_wr, quiet;
  assign sem_wr = reg_we && reg_addr[3:2] == 2'd3;
  assign quiet  = !gate && !chan_rst && !err_st;

  // R4
  fetch_needs_count_chk: assert property (@(posedge clk) disable iff (rst)
    mem_req_valid |-> sema != '0);

  // R6
  sema_step_chk: assert property (@(posedge clk) disable iff (rst)
    (!sem_wr && !chan_rst) |=> (sema == $past(sema) || sema == $past(sema) - 1'b1));

  // R10
  gate_halt_chk: assert property (@(posedge clk) disable iff (rst)
    gate |=> (!cmd_valid && !mem_req_valid));

  // R11
  chan_reset_chk: assert property (@(posedge clk) disable iff (rst)
    chan_rst |=> (sema == '0 && !cmd_valid && !mem_req_valid));

  // R8
  err_park_chk: assert property (@(posedge clk) disable iff (rst)
    err_st |=> (!cmd_valid && !mem_req_valid));

  // R5
  cmd_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && !cmd_ready && quiet) |=> (cmd_valid && $stable(cmd_addr)));

  // R12
  req_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_req_valid && !mem_req_ready && quiet) |=> (mem_req_valid && $stable(mem_req_addr)));
endmodule

bind desc_chain_seq dcs_chk #(.AW(AW), .SW(SW), .RAW(RAW)) u_chk (
  .clk, .rst, .gate, .chan_rst, .err_st, .sema, .reg_we, .reg_addr,
  .mem_req_valid, .mem_req_ready, .mem_req_addr, .cmd_valid, .cmd_ready, .cmd_addr
);

// File: tb/desc_chain_seq_tb.sv
`timescale 1ns/1ps
module desc_chain_seq_tb;
  logic        clk = 0, rst = 1;
  logic        reg_we = 0;
  logic [3:0]  reg_addr = 0;
  logic [31:0] reg_wdata = 0, reg_rdata;
  logic        mem_req_valid, mem_req_ready, mem_rsp_valid = 0;
  logic [31:0] mem_req_addr, mem_rsp_data = 0;
  logic        cmd_valid, cmd_ready = 1, xfer_done = 0, irq;
  logic [31:0] cmd_addr;
  logic [15:0] cmd_count;

  logic [31:0] mem [0:63];
  logic [31:0] lg_addr [0:255];
  logic [15:0] lg_cnt  [0:255];
  int nreq = 0, ncmd = 0, mv_cnt = 0, nchk = 0, nfail = 0;
  logic stall_en = 0, ph = 0;

  always #10 clk = ~clk;

  desc_chain_seq u_dut (.*);

  assign mem_req_ready = !(stall_en && ph);

  always @(posedge clk) begin
    ph <= ~ph;
    if (rst) mem_rsp_valid <= 0;
    else begin
      mem_rsp_valid <= mem_req_valid && mem_req_ready;
      mem_rsp_data  <= mem[mem_req_addr[7:2]];
      if (mem_req_valid && mem_req_ready) nreq <= nreq + 1;
    end
  end

  always @(posedge clk) begin
    if (rst) begin mv_cnt <= 0; xfer_done <= 0; end
    else begin
      xfer_done <= (mv_cnt == 1);
      if (cmd_valid && cmd_ready) begin
        lg_addr[ncmd[7:0]] <= cmd_addr;
        lg_cnt[ncmd[7:0]]  <= cmd_count;
        ncmd   <= ncmd + 1;
        mv_cnt <= 3;
      end else if (mv_cnt != 0) mv_cnt <= mv_cnt - 1;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk); reg_we = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_we = 0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk); reg_addr = a;
    @(negedge clk); d = reg_rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic put_desc(input int i, input int nx, input bit ch, input bit dc,
                          input bit iq, input int cnt);
    mem[i*4]   = nx * 16;
    mem[i*4+1] = (32'(iq) << 18) | (32'(dc) << 17) | (32'(ch) << 16) | 32'(cnt);
    mem[i*4+2] = 32'h1000 + i * 16;
    mem[i*4+3] = 0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin
    logic [31:0] v;
    int b, r;
    for (int i = 0; i < 64; i++) mem[i] = 0;
    put_desc(0, 1, 1, 1, 0, 5);
    put_desc(1, 2, 1, 1, 0, 6);
    put_desc(2, 0, 0, 1, 1, 7);
    put_desc(4, 5, 1, 0, 0, 8);
    put_desc(5, 0, 0, 1, 0, 9);
    put_desc(6, 7, 1, 1, 0, 10);
    put_desc(7, 6, 1, 1, 0, 11);
    put_desc(8, 0, 0, 1, 0, 12);
    for (int i = 9; i < 13; i++) put_desc(i, (i == 12) ? 9 : i + 1, 1, 1, 0, 100 + i);
    idle(5);
    rst = 0;

    // R1 reset state
    rd(4'd0, v);  chk("R1 gate after reset", v, 32'h1);
    rd(4'd12, v); chk("R1 sema after reset", v, 0);
    rd(4'd4, v);  chk("R1 int after reset", v, 0);
    rd(4'd8, v);  chk("R1 next after reset", v, 0);
    chk("R1 outputs idle", {31'b0, irq | cmd_valid | mem_req_valid}, 0);

    // R2 alias writes
    wr(4'd4, 32'h300); rd(4'd4, v); chk("R2 base write", v, 32'h300);
    wr(4'd6, 32'h100); rd(4'd4, v); chk("R2 clear alias", v, 32'h200);
    wr(4'd5, 32'h100); rd(4'd4, v); chk("R2 set alias", v, 32'h300);
    wr(4'd8, 32'h40);  rd(4'd8, v); chk("R2 next write", v, 32'h40);

    // R3 add while gated, R10 gate blocks fetch
    b = nreq;
    wr(4'd12, 2); idle(20);
    chk("R10 no fetch while gated", nreq - b, 0);
    wr(4'd12, 3); rd(4'd12, v); chk("R3 sema adds", v, 5);
    wr(4'd12, 255); rd(4'd12, v); chk("R3 sema saturates", v, 255);
    // R11 channel reset
    wr(4'd1, 2); rd(4'd12, v); chk("R11 sema cleared", v, 0);
    rd(4'd0, v); chk("R11 reset bit reads 0", v, 1);

    // R4 R5 R7 R9 basic three-entry chain
    wr(4'd8, 0); b = ncmd; r = nreq;
    wr(4'd12, 3); wr(4'd2, 1); idle(150);
    chk("R7 three commands", ncmd - b, 3);
    chk("R4 three fetches each", nreq - r, 9);
    for (int k = 0; k < 3; k++) begin
      chk("R5 cmd addr", lg_addr[(b+k) % 256], 32'h1000 + k*16);
      chk("R4 cmd count", 32'(lg_cnt[(b+k) % 256]), 5 + k);
    end
    rd(4'd12, v); chk("R6 sema drained", v, 0);
    rd(4'd8, v);  chk("R7 next follows link", v, 32'h20);
    rd(4'd4, v);  chk("R9 done status", v, 32'h301);
    chk("R9 irq raised", 32'(irq), 1);
    wr(4'd6, 1); idle(3);
    chk("R9 irq drops", 32'(irq), 0);

    // R6 command without decrement
    wr(4'd8, 32'h40); b = ncmd;
    wr(4'd12, 1); idle(100);
    chk("R6 no-dec continues", ncmd - b, 2);
    rd(4'd12, v); chk("R6 sema after", v, 0);
    rd(4'd4, v);  chk("R9 no done without flag", v, 32'h300);

    // R7 stop at zero in endless ring
    wr(4'd8, 32'h60); b = ncmd;
    wr(4'd12, 1); idle(100);
    chk("R7 stops at zero", ncmd - b, 1);
    rd(4'd8, v); chk("R7 next loaded", v, 32'h70);

    // R8 list end with count left
    wr(4'd8, 32'h80); b = ncmd; r = nreq;
    wr(4'd12, 3); idle(100);
    chk("R8 one command", ncmd - b, 1);
    rd(4'd12, v); chk("R8 sema left", v, 2);
    rd(4'd4, v);  chk("R8 error status", v, 32'h302);
    chk("R8 irq on error", 32'(irq), 1);
    chk("R8 parked", nreq - r, 3);
    wr(4'd6, 2); idle(100);
    chk("R8 resumes after clear", ncmd - b, 2);
    rd(4'd12, v); chk("R8 sema after resume", v, 1);
    wr(4'd1, 2); wr(4'd6, 2); idle(20);
    chk("R11 reset stops", ncmd - b, 2);
    rd(4'd4, v); chk("R8 error cleared", v, 32'h300);

    // R3 add while running
    wr(4'd8, 32'h60); b = ncmd;
    wr(4'd12, 1);
    while (ncmd == b) @(negedge clk);
    wr(4'd12, 2); idle(150);
    chk("R3 extended chain", ncmd - b, 3);
    rd(4'd12, v); chk("R3 sema drained", v, 0);

    // R10 abort while waiting for acceptance
    cmd_ready = 0; wr(4'd8, 32'h60); b = ncmd;
    wr(4'd12, 2);
    while (!cmd_valid) @(negedge clk);
    wr(4'd1, 1); idle(2);
    chk("R10 cmd dropped", 32'(cmd_valid), 0);
    cmd_ready = 1; idle(20);
    chk("R10 no command issued", ncmd - b, 0);
    rd(4'd12, v); chk("R10 sema kept", v, 2);
    wr(4'd1, 2); wr(4'd2, 1);

    // R7 R12 sweep over ring of four, with and without stalls
    for (int n = 1; n <= 6; n++) begin
      stall_en = n[0];
      wr(4'd8, 32'h90); b = ncmd; r = nreq;
      wr(4'd12, n); idle(40 * n + 20);
      chk("R7 sweep count", ncmd - b, n);
      chk("R12 sweep fetches", nreq - r, 3 * n);
      chk("R7 sweep last buffer", lg_addr[(ncmd-1) % 256], 32'h1000 + (9 + (n-1) % 4) * 16);
      rd(4'd8, v); chk("R7 sweep next", v, (9 + n % 4) * 16);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule